// File: doc/BRIEF.md
# Transactional Cache Conflict Tracker

This block follows one hardware transaction at a time on behalf of a local core. While a transaction runs, each line the core loads joins a read-set, each line it stores to joins a write-set, and store data is parked in a per-line shadow copy instead of the committed line array. Other agents reach the committed array only through snoops, so they never see speculative data. A snoop that collides with the tracked sets aborts the transaction. The abort throws away the shadow data and sends the core back to the fallback address it gave when the transaction began. It does not matter whether the snooping agent is itself transactional.

Control is a two-state machine. `IDLE` has one transition, BEGIN (a `tx_begin_i` pulse), which captures the fallback address and moves to `ACTIVE`. `ACTIVE` has two transitions back to `IDLE`. ABORT is taken on a snoop conflict or a capacity overflow. COMMIT is taken on `tx_commit_i` when no abort occurs in the same cycle, and it copies every shadow line into the committed array in one cycle. The tracker has `NWAYS` fully associative tracking ways. The committed array holds every one of the `2**ADDR_W` lines.

Loads return data combinationally. A line that is in the write-set returns its shadow copy; any other line returns the committed value. The core issues no load or store in the same cycle as a commit.

Top module: `txn_conflict_tracker`

## Requirements
- R1: While `ACTIVE`, a load marks its line as read-set. A later write snoop to that line aborts, and a repeated load to a line already tracked takes no new way.
- R2: While `ACTIVE`, a store marks its line as write-set. A later read snoop to that line aborts with cause 1 (conflict).
- R3: A read snoop to a line that is only in the read-set causes no abort.
- R4: A write snoop to a line in either set aborts with cause 1.
- R5: A snoop to an untracked line, or any snoop while `IDLE`, causes no abort. `snp_data_o` always shows the committed value of `snp_addr_i`.
- R6: An abort raises `abort_o` for exactly one cycle, starting the cycle after the triggering edge. In that cycle `redirect_pc_o` holds the fallback address captured at BEGIN and `tx_active_o` is low.
- R7: Inside a transaction, `ld_data_o` returns the speculative store data, while `snp_data_o` for the same line still returns the old committed value.
- R8: COMMIT writes every write-set line into the committed array and clears `tx_active_o`, both at the same edge. After that edge, snoops see the new data.
- R9: After an abort, the committed array holds no speculative data. Loads and snoops see the old values, or the value written by the conflicting write snoop.
- R10: A transactional access to an untracked line when all `NWAYS` ways are in use aborts with cause 2 (capacity). Snoop conflict takes priority over capacity.
- R11: If a conflict and a commit arrive in the same cycle, the abort wins and nothing is committed.
- R12: BEGIN while `ACTIVE` is ignored, and the first fallback address is kept. COMMIT while `IDLE` has no effect.
- R13: A store while `IDLE` (including the BEGIN cycle) writes the committed array directly. The new value is visible from the next cycle.
- R14: After reset the block is `IDLE`, `abort_o` is low, the cause is 0, and every committed line reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin_i | input | 1 | Start a transaction (BEGIN) |
| fallback_pc_i | input | PC_W | Fallback address, captured at BEGIN |
| tx_commit_i | input | 1 | Commit request |
| ld_req_i | input | 1 | Core load request |
| st_req_i | input | 1 | Core store request |
| acc_addr_i | input | ADDR_W | Line address of the core access |
| st_data_i | input | DATA_W | Store data |
| ld_data_o | output | DATA_W | Load data for `acc_addr_i` (combinational) |
| snp_valid_i | input | 1 | Snoop present |
| snp_write_i | input | 1 | Snoop type: 1 write, 0 read |
| snp_addr_i | input | ADDR_W | Snoop line address |
| snp_data_i | input | DATA_W | Data carried by a write snoop |
| snp_data_o | output | DATA_W | Committed data for `snp_addr_i` (combinational) |
| tx_active_o | output | 1 | Machine is in `ACTIVE` |
| abort_o | output | 1 | One-cycle abort and redirect pulse |
| abort_cause_o | output | 2 | 0 none, 1 conflict, 2 capacity |
| redirect_pc_o | output | PC_W | Redirect target while `abort_o` is high |

## Verification
The two data outputs are combinational. They are checked one time step after the address is driven, with no clock edge between drive and check. Every state-related result passes through one register: `abort_o`, `abort_cause_o`, `redirect_pc_o`, `tx_active_o` and the committed array are all checked just after the edge that sampled the stimulus, and `abort_o` is checked again one edge later to confirm that it is a single pulse. A sweep covers each tracked-set state (none, read, write, both) against each snoop type, for both a hit and a miss. The expected abort decision and the expected committed data are computed arithmetically for each case.

// File: rtl/txn_pkg.sv
package txn_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_CONFLICT = 2'd1,
        CAUSE_CAPACITY = 2'd2
    } abort_cause_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } txn_state_e;
endpackage

// File: rtl/txn_track_set.sv
module txn_track_set #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int NWAYS  = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clear_i,
    input  logic                               acc_en_i,
    input  logic                               acc_st_i,
    input  logic [ADDR_W-1:0]                  acc_addr_i,
    input  logic [DATA_W-1:0]                  st_data_i,
    input  logic                               snp_valid_i,
    input  logic                               snp_write_i,
    input  logic [ADDR_W-1:0]                  snp_addr_i,
    output logic                               fwd_valid_o,
    output logic [DATA_W-1:0]                  fwd_data_o,
    output logic                               full_miss_o,
    output logic                               conflict_o,
    output logic [NWAYS-1:0]                   wb_en_o,
    output logic [NWAYS-1:0][ADDR_W-1:0]       wb_addr_o,
    output logic [NWAYS-1:0][DATA_W-1:0]       wb_data_o
);
    localparam int IDX_W = (NWAYS > 1) ? $clog2(NWAYS) : 1;

    logic [NWAYS-1:0]              vld_q, rd_q, wr_q;
    logic [NWAYS-1:0][ADDR_W-1:0]  tag_q;
    logic [NWAYS-1:0][DATA_W-1:0]  shadow_q;
    logic [NWAYS-1:0]              hit_vec, snp_vec;
    logic [IDX_W-1:0]              hit_idx, free_idx;
    logic                          any_hit;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        assign hit_vec[w]   = vld_q[w] && (tag_q[w] == acc_addr_i);
        assign snp_vec[w]   = vld_q[w] && (tag_q[w] == snp_addr_i);
        assign wb_en_o[w]   = vld_q[w] && wr_q[w];
        assign wb_addr_o[w] = tag_q[w];
        assign wb_data_o[w] = shadow_q[w];
    end

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = NWAYS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
            if (!vld_q[i])  free_idx = IDX_W'(i);
        end
    end

    assign any_hit     = |hit_vec;
    assign full_miss_o = !any_hit && (&vld_q);
    assign fwd_valid_o = any_hit && wr_q[hit_idx];
    assign fwd_data_o  = shadow_q[hit_idx];
    assign conflict_o  = snp_valid_i &&
                         (|(snp_vec & (wr_q | (snp_write_i ? rd_q : '0))));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= '0;
            rd_q     <= '0;
            wr_q     <= '0;
            tag_q    <= '0;
            shadow_q <= '0;
        end else if (clear_i) begin
            vld_q <= '0;
            rd_q  <= '0;
            wr_q  <= '0;
        end else if (acc_en_i) begin
            if (any_hit) begin
                if (acc_st_i) begin
                    wr_q[hit_idx]     <= 1'b1;
                    shadow_q[hit_idx] <= st_data_i;
                end else begin
                    rd_q[hit_idx] <= 1'b1;
                end
            end else if (!(&vld_q)) begin
                vld_q[free_idx]    <= 1'b1;
                tag_q[free_idx]    <= acc_addr_i;
                rd_q[free_idx]     <= !acc_st_i;
                wr_q[free_idx]     <= acc_st_i;
                shadow_q[free_idx] <= st_data_i;
            end
        end
    end

    // R1: a line is never tracked by two ways at once
    p_unique_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    // R2: a read snoop can only conflict when some line was stored to
    p_read_conflict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict_o && !snp_write_i) |-> (wr_q != '0));
    // R9: abort or commit leaves no tracked line behind
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (vld_q == '0));
endmodule

// File: rtl/txn_commit_store.sv
module txn_commit_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int NWAYS  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         core_we_i,
    input  logic [ADDR_W-1:0]            core_addr_i,
    input  logic [DATA_W-1:0]            core_data_i,
    input  logic                         snp_we_i,
    input  logic [ADDR_W-1:0]            snp_addr_i,
    input  logic [DATA_W-1:0]            snp_data_i,
    input  logic                         commit_i,
    input  logic [NWAYS-1:0]             wb_en_i,
    input  logic [NWAYS-1:0][ADDR_W-1:0] wb_addr_i,
    input  logic [NWAYS-1:0][DATA_W-1:0] wb_data_i,
    output logic [DATA_W-1:0]            core_rdata_o,
    output logic [DATA_W-1:0]            snp_rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] line_q [DEPTH];

    assign core_rdata_o = line_q[core_addr_i];
    assign snp_rdata_o  = line_q[snp_addr_i];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
        end else begin
            if (snp_we_i)  line_q[snp_addr_i]  <= snp_data_i;
            if (core_we_i) line_q[core_addr_i] <= core_data_i;
            if (commit_i) begin
                for (int w = 0; w < NWAYS; w++)
                    if (wb_en_i[w]) line_q[wb_addr_i[w]] <= wb_data_i[w];
            end
        end
    end
endmodule

// File: rtl/txn_ctrl.sv
module txn_ctrl
    import txn_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            begin_i,
    input  logic            commit_i,
    input  logic [PC_W-1:0] fallback_pc_i,
    input  logic            conflict_i,
    input  logic            tx_access_i,
    input  logic            full_miss_i,
    output logic            active_o,
    output logic            abort_now_o,
    output logic            commit_now_o,
    output logic            abort_o,
    output logic [1:0]      cause_o,
    output logic [PC_W-1:0] redirect_pc_o
);
    txn_state_e      state_q, state_d;
    logic [PC_W-1:0] pc_q;
    logic            conflict_hit, capacity_hit;

    assign active_o     = (state_q == ST_ACTIVE);
    assign conflict_hit = active_o && conflict_i;
    assign capacity_hit = active_o && tx_access_i && full_miss_i;
    assign abort_now_o  = conflict_hit || capacity_hit;
    assign commit_now_o = active_o && commit_i && !abort_now_o;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (begin_i) state_d = ST_ACTIVE;
            ST_ACTIVE: if (abort_now_o || commit_now_o) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && begin_i) pc_q <= fallback_pc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_o       <= 1'b0;
            cause_o       <= CAUSE_NONE;
            redirect_pc_o <= '0;
        end else begin
            abort_o <= abort_now_o;
            if (abort_now_o) begin
                cause_o       <= conflict_hit ? CAUSE_CONFLICT : CAUSE_CAPACITY;
                redirect_pc_o <= pc_q;
            end else begin
                cause_o <= CAUSE_NONE;
            end
        end
    end

    // R6: abort is a single-cycle pulse and the transaction is over
    p_abort_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);
    p_abort_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !active_o);
    // R5: no abort follows a cycle spent idle
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |=> !abort_o);
    // R11: conflict beats a same-cycle commit
    p_abort_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && conflict_i && commit_i) |=> (abort_o && cause_o == CAUSE_CONFLICT));
    // R10: capacity overflow without conflict reports the capacity code
    p_capacity_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !conflict_i && tx_access_i && full_miss_i) |=> (cause_o == CAUSE_CAPACITY));
    // R12: a nested begin keeps the first fallback address
    p_pc_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && begin_i) |=> $stable(pc_q));
endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int NWAYS  = 4,
    parameter int PC_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_begin_i,
    input  logic [PC_W-1:0]   fallback_pc_i,
    input  logic              tx_commit_i,
    input  logic              ld_req_i,
    input  logic              st_req_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [DATA_W-1:0] st_data_i,
    output logic [DATA_W-1:0] ld_data_o,
    input  logic              snp_valid_i,
    input  logic              snp_write_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic [DATA_W-1:0] snp_data_i,
    output logic [DATA_W-1:0] snp_data_o,
    output logic              tx_active_o,
    output logic              abort_o,
    output logic [1:0]        abort_cause_o,
    output logic [PC_W-1:0]   redirect_pc_o
);
    logic                          active, abort_now, commit_now;
    logic                          fwd_valid, full_miss, conflict;
    logic [DATA_W-1:0]             fwd_data, core_rdata;
    logic [NWAYS-1:0]              wb_en;
    logic [NWAYS-1:0][ADDR_W-1:0]  wb_addr;
    logic [NWAYS-1:0][DATA_W-1:0]  wb_data;
    logic                          tx_access;

    assign tx_access = ld_req_i || st_req_i;

    txn_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .begin_i       (tx_begin_i),
        .commit_i      (tx_commit_i),
        .fallback_pc_i (fallback_pc_i),
        .conflict_i    (conflict),
        .tx_access_i   (tx_access),
        .full_miss_i   (full_miss),
        .active_o      (active),
        .abort_now_o   (abort_now),
        .commit_now_o  (commit_now),
        .abort_o       (abort_o),
        .cause_o       (abort_cause_o),
        .redirect_pc_o (redirect_pc_o)
    );

    txn_track_set #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWAYS(NWAYS)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (abort_now || commit_now),
        .acc_en_i    (active && tx_access),
        .acc_st_i    (st_req_i),
        .acc_addr_i  (acc_addr_i),
        .st_data_i   (st_data_i),
        .snp_valid_i (snp_valid_i),
        .snp_write_i (snp_write_i),
        .snp_addr_i  (snp_addr_i),
        .fwd_valid_o (fwd_valid),
        .fwd_data_o  (fwd_data),
        .full_miss_o (full_miss),
        .conflict_o  (conflict),
        .wb_en_o     (wb_en),
        .wb_addr_o   (wb_addr),
        .wb_data_o   (wb_data)
    );

    txn_commit_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWAYS(NWAYS)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_we_i    (st_req_i && !active),
        .core_addr_i  (acc_addr_i),
        .core_data_i  (st_data_i),
        .snp_we_i     (snp_valid_i && snp_write_i),
        .snp_addr_i   (snp_addr_i),
        .snp_data_i   (snp_data_i),
        .commit_i     (commit_now),
        .wb_en_i      (wb_en),
        .wb_addr_i    (wb_addr),
        .wb_data_i    (wb_data),
        .core_rdata_o (core_rdata),
        .snp_rdata_o  (snp_data_o)
    );

    assign tx_active_o = active;
    assign ld_data_o   = (active && fwd_valid) ? fwd_data : core_rdata;
endmodule

// File: tb/txn_conflict_tracker_tb.sv
module txn_conflict_tracker_tb;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int NWAYS  = 4;
    localparam int PC_W   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_begin_i = 1'b0;
    logic [PC_W-1:0]   fallback_pc_i = '0;
    logic              tx_commit_i = 1'b0;
    logic              ld_req_i = 1'b0;
    logic              st_req_i = 1'b0;
    logic [ADDR_W-1:0] acc_addr_i = '0;
    logic [DATA_W-1:0] st_data_i = '0;
    logic [DATA_W-1:0] ld_data_o;
    logic              snp_valid_i = 1'b0;
    logic              snp_write_i = 1'b0;
    logic [ADDR_W-1:0] snp_addr_i = '0;
    logic [DATA_W-1:0] snp_data_i = '0;
    logic [DATA_W-1:0] snp_data_o;
    logic              tx_active_o;
    logic              abort_o;
    logic [1:0]        abort_cause_o;
    logic [PC_W-1:0]   redirect_pc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    txn_conflict_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWAYS(NWAYS), .PC_W(PC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_begin_i(tx_begin_i), .fallback_pc_i(fallback_pc_i),
        .tx_commit_i(tx_commit_i), .ld_req_i(ld_req_i), .st_req_i(st_req_i),
        .acc_addr_i(acc_addr_i), .st_data_i(st_data_i), .ld_data_o(ld_data_o),
        .snp_valid_i(snp_valid_i), .snp_write_i(snp_write_i), .snp_addr_i(snp_addr_i),
        .snp_data_i(snp_data_i), .snp_data_o(snp_data_o), .tx_active_o(tx_active_o),
        .abort_o(abort_o), .abort_cause_o(abort_cause_o), .redirect_pc_o(redirect_pc_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic peek(input logic [ADDR_W-1:0] a);
        acc_addr_i = a;
        snp_addr_i = a;
        #1;
    endtask

    task automatic do_begin(input logic [PC_W-1:0] pc);
        tx_begin_i = 1'b1; fallback_pc_i = pc;
        tick();
        tx_begin_i = 1'b0;
    endtask

    task automatic do_load(input logic [ADDR_W-1:0] a);
        ld_req_i = 1'b1; acc_addr_i = a;
        tick();
        ld_req_i = 1'b0;
    endtask

    task automatic do_store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        st_req_i = 1'b1; acc_addr_i = a; st_data_i = d;
        tick();
        st_req_i = 1'b0;
    endtask

    task automatic do_snoop(input bit w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        snp_valid_i = 1'b1; snp_write_i = w; snp_addr_i = a; snp_data_i = d;
        tick();
        snp_valid_i = 1'b0; snp_write_i = 1'b0;
    endtask

    task automatic do_commit();
        tx_commit_i = 1'b1;
        tick();
        tx_commit_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        tick();
        peek(0);
        chk("R14 active", int'(tx_active_o), 0);
        chk("R14 abort", int'(abort_o), 0);
        chk("R14 cause", int'(abort_cause_o), 0);
        chk("R14 line zero", int'(snp_data_o), 0);

        // R1 R2 R3 R4 R5 R7 R8 R9 R13: set-state x snoop-type x hit sweep
        for (int c = 0; c < 16; c++) begin
            int kind = c & 3;
            bit w    = c[2];
            bit hit  = c[3];
            logic [ADDR_W-1:0] a  = ADDR_W'(c);
            logic [ADDR_W-1:0] sa = hit ? a : (a ^ ADDR_W'(1));
            logic [DATA_W-1:0] o  = DATA_W'(8'h10 + c);
            logic [DATA_W-1:0] d  = DATA_W'(8'h40 + c);
            logic [PC_W-1:0]  pc  = PC_W'(16'h100 + c);
            bit exp_abort = hit && ((kind & 2) != 0 || (w && kind != 0));
            int exp_mem;

            do_store(a, o);
            peek(a);
            chk("R13 idle store", int'(snp_data_o), int'(o));
            do_begin(pc);
            chk("R6 active after begin", int'(tx_active_o), 1);
            if ((kind & 1) != 0) do_load(a);
            if ((kind & 2) != 0) begin
                do_store(a, d);
                peek(a);
                chk("R7 local sees shadow", int'(ld_data_o), int'(d));
                chk("R7 snoop sees old", int'(snp_data_o), int'(o));
            end
            do_snoop(w, sa, 8'hEE);
            chk(exp_abort ? "R4 R2 R1 conflict abort" : "R3 R5 no abort",
                int'(abort_o), int'(exp_abort));
            if (exp_abort) begin
                chk("R4 cause conflict", int'(abort_cause_o), 1);
                chk("R6 redirect pc", int'(redirect_pc_o), int'(pc));
                chk("R6 inactive", int'(tx_active_o), 0);
                exp_mem = w ? 8'hEE : int'(o);
                peek(a);
                chk("R9 snoop sees rollback", int'(snp_data_o), exp_mem);
                chk("R9 load sees rollback", int'(ld_data_o), exp_mem);
                tick();
                chk("R6 pulse width", int'(abort_o), 0);
            end else begin
                do_commit();
                chk("R8 inactive after commit", int'(tx_active_o), 0);
                chk("R8 no abort on commit", int'(abort_o), 0);
                if ((kind & 2) != 0)      exp_mem = int'(d);
                else if (w && hit)        exp_mem = 8'hEE;
                else                      exp_mem = int'(o);
                peek(a);
                chk("R8 committed data", int'(snp_data_o), exp_mem);
            end
        end

        // R5: snoops while idle never abort
        for (int w = 0; w < 2; w++) begin
            do_snoop(w[0], 4'h5, 8'h77);
            chk("R5 idle snoop", int'(abort_o), 0);
        end

        // R10 R1: fill every way, reuse one, then overflow
        do_begin(16'hCAFE);
        for (int i = 0; i < NWAYS; i++) begin
            do_load(ADDR_W'(i));
            chk("R10 within capacity", int'(abort_o), 0);
        end
        do_load(0);
        chk("R1 reload no new way", int'(abort_o), 0);
        do_load(ADDR_W'(NWAYS));
        chk("R10 capacity abort", int'(abort_o), 1);
        chk("R10 capacity cause", int'(abort_cause_o), 2);
        chk("R10 capacity redirect", int'(redirect_pc_o), 16'hCAFE);

        // R11: conflict and commit in one cycle
        do_store(4'h9, 8'h21);
        do_begin(16'h0B0B);
        do_store(4'h9, 8'h99);
        tx_commit_i = 1'b1;
        do_snoop(1'b0, 4'h9, 8'h00);
        tx_commit_i = 1'b0;
        chk("R11 abort wins", int'(abort_o), 1);
        chk("R11 cause", int'(abort_cause_o), 1);
        peek(4'h9);
        chk("R11 nothing committed", int'(snp_data_o), 8'h21);

        // R12: nested begin ignored, idle commit ignored
        tick();
        do_commit();
        chk("R12 idle commit active", int'(tx_active_o), 0);
        chk("R12 idle commit abort", int'(abort_o), 0);
        do_begin(16'h1111);
        do_begin(16'h2222);
        chk("R12 still active", int'(tx_active_o), 1);
        do_store(4'h3, 8'h55);
        do_snoop(1'b1, 4'h3, 8'h66);
        chk("R12 abort", int'(abort_o), 1);
        chk("R12 first pc kept", int'(redirect_pc_o), 16'h1111);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule